// File: doc/BRIEF.md
# Byte-wide flash command interface

This block is the device side of a byte-wide flash memory's command path. It samples chip enable, output enable and write enable against a system clock. It also takes a flag that reports whether the programming supply is at its high level. Write cycles carry command bytes, which move the block between a small set of modes: plain array read, identification read, erase, erase check, program, program check and the two-step reset. The mode decides what a read cycle returns.

Program and erase pulses run under an internal stop timer, counted in clock cycles, and `busy_o` stays high while a pulse is running. The memory cells are modelled as a small register file. A byte can only have bits cleared by programming, and erase sets every byte back to all ones. A pulse takes effect only if its timer runs out. Any pulse that is cut short leaves the array untouched.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in array-read mode. `busy_o` is 0 and every array byte reads FFh.
- R2: A write cycle is a low-to-high transition of `we_n_i` while `ce_n_i` is low. Its byte is taken as a command only while `vpp_hi_i` is 1. While `vpp_hi_i` is 0, the block is held in array-read mode, write cycles are ignored, and a running pulse is stopped without touching the array.
- R3: Command 90h selects identification read. A read then returns 31h when address bit 0 is 0 and BDh when it is 1.
- R4: Command 40h followed by a second write cycle starts a program pulse. The address is taken at the falling edge of `we_n_i` in that second cycle and the data byte at its rising edge. `busy_o` is high for PROG_CYC cycles, and the target byte then becomes its old value ANDed with the data byte.
- R5: Two write cycles of 20h start an erase pulse. `busy_o` is high for ERASE_CYC cycles, after which every byte is FFh. If the second byte is not 20h, the block returns to array-read mode and starts no pulse.
- R6: Command A0h takes its address at the falling edge of `we_n_i` in its own cycle. Command C0h keeps the address of the last program cycle. In both check modes a read returns the byte at the held address, whatever `addr_i` is.
- R7: Any write cycle that arrives during a pulse ends the pulse at once. This includes a check command. `busy_o` falls and the array keeps its old contents.
- R8: Two consecutive write cycles of FFh return the block to array-read mode from any mode.
- R9: A command byte outside 00h, 90h, 20h, A0h, 40h, C0h and FFh returns the block to array-read mode.
- R10: `data_oe_o` is 1 only when `ce_n_i` is 0, `oe_n_i` is 0 and `we_n_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| vpp_hi_i | input | 1 | Programming supply at high level |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data / command byte |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data drive enable |
| busy_o | output | 1 | Program or erase pulse running |

## Verification
The hardest state to reach from the ports is a pulse that is cut off partway. This needs a second write cycle, or a drop of the supply flag, to land inside the PROG_CYC window and before the commit edge. The stimulus reaches it by issuing the interrupting cycle as soon as the start cycle has finished, when `busy_o` is known to be high. It then reads back the target byte, which must still hold its old value. Both check modes are tested with a read address that differs from the held address, so that a stale or wrongly timed address latch shows up at `data_o`.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    S_READ, S_SIG, S_ERS_SET, S_ERS_RUN, S_ERS_VFY,
    S_PRG_SET, S_PRG_RUN, S_PRG_VFY, S_RST_SET
  } mode_e;

  localparam logic [7:0] C_READ  = 8'h00;
  localparam logic [7:0] C_SIG   = 8'h90;
  localparam logic [7:0] C_ERS   = 8'h20;
  localparam logic [7:0] C_EVFY  = 8'hA0;
  localparam logic [7:0] C_PRG   = 8'h40;
  localparam logic [7:0] C_PVFY  = 8'hC0;
  localparam logic [7:0] C_RST   = 8'hFF;
  localparam logic [7:0] SIG_MFG = 8'h31;
  localparam logic [7:0] SIG_DEV = 8'hBD;

  function automatic mode_e decode_cmd(input logic [7:0] b);
    case (b)
      C_READ:  return S_READ;
      C_SIG:   return S_SIG;
      C_ERS:   return S_ERS_SET;
      C_EVFY:  return S_ERS_VFY;
      C_PRG:   return S_PRG_SET;
      C_PVFY:  return S_PRG_VFY;
      C_RST:   return S_RST_SET;
      default: return S_READ;
    endcase
  endfunction
endpackage

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  input  logic cancel_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(1)) && !cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= long_i ? CW'(ERASE_CYC) : CW'(PROG_CYC);
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  a_r4_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !cancel_i |=> busy_o);
  a_r7_cancel_drops_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cancel_i |=> !busy_o);
  a_r4_done_ends_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !busy_o);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (prog_i) begin
      mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i;
    end
  end

  // programming may only clear bits
  a_r4_prog_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i && !erase_i |=> (mem_q[$past(wr_addr_i)] & ~$past(mem_q[wr_addr_i])) == 8'h00);
  a_r5_erase_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              vpp_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              busy_i,
  input  logic              done_i,
  output mode_e             mode_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              start_o,
  output logic              long_o,
  output logic              cancel_o,
  output logic              prog_o,
  output logic              erase_o
);
  mode_e             mode_q, mode_d;
  logic              we_q;
  logic              wr_fall, wr_rise, lat_addr;
  logic [ADDR_W-1:0] pend_addr_q, tgt_addr_q;
  logic [7:0]        prog_data_q;

  assign wr_fall = !ce_n_i && we_q && !we_n_i;
  assign wr_rise = !ce_n_i && !we_q && we_n_i;

  always_comb begin
    mode_d   = mode_q;
    start_o  = 1'b0;
    long_o   = 1'b0;
    cancel_o = 1'b0;
    if (!vpp_hi_i) begin
      mode_d   = S_READ;
      cancel_o = busy_i;
    end else if (wr_rise) begin
      cancel_o = busy_i;
      case (mode_q)
        S_ERS_SET: begin
          if (data_i == C_ERS) begin
            mode_d  = S_ERS_RUN;
            start_o = 1'b1;
            long_o  = 1'b1;
          end else begin
            mode_d = S_READ;
          end
        end
        S_PRG_SET: begin
          mode_d  = S_PRG_RUN;
          start_o = 1'b1;
        end
        S_RST_SET: mode_d = (data_i == C_RST) ? S_READ : decode_cmd(data_i);
        default:   mode_d = decode_cmd(data_i);
      endcase
    end
  end

  // address taken at the falling edge is kept only by program data or erase-check cycles
  assign lat_addr = vpp_hi_i && wr_rise && (mode_q == S_PRG_SET || mode_d == S_ERS_VFY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= S_READ;
      we_q        <= 1'b1;
      pend_addr_q <= '0;
      tgt_addr_q  <= '0;
      prog_data_q <= 8'hFF;
    end else begin
      mode_q <= mode_d;
      we_q   <= we_n_i;
      if (wr_fall) pend_addr_q <= addr_i;
      if (lat_addr) tgt_addr_q <= pend_addr_q;
      if (vpp_hi_i && wr_rise && mode_q == S_PRG_SET) prog_data_q <= data_i;
    end
  end

  assign mode_o      = mode_q;
  assign tgt_addr_o  = tgt_addr_q;
  assign prog_data_o = prog_data_q;
  assign prog_o      = done_i && (mode_q == S_PRG_RUN);
  assign erase_o     = done_i && (mode_q == S_ERS_RUN);

  a_r2_vpp_low_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_hi_i |=> mode_q == S_READ);
  a_r8_double_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_hi_i && wr_rise && mode_q == S_RST_SET && data_i == C_RST |=> mode_q == S_READ);
  a_r6_vfy_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == S_PRG_VFY && !wr_rise |=> $stable(tgt_addr_q));
  a_r7_write_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_hi_i && wr_rise && busy_i |-> cancel_o && !prog_o && !erase_o);
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              vpp_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  mode_e             mode;
  logic [ADDR_W-1:0] tgt_addr, rd_addr;
  logic [7:0]        prog_data, rd_data;
  logic              start, long_p, cancel, done, busy, prog, erase;

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .ce_n_i, .we_n_i, .vpp_hi_i, .addr_i, .data_i,
    .busy_i(busy), .done_i(done), .mode_o(mode), .tgt_addr_o(tgt_addr),
    .prog_data_o(prog_data), .start_o(start), .long_o(long_p),
    .cancel_o(cancel), .prog_o(prog), .erase_o(erase)
  );

  flash_pulse_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .long_i(long_p), .cancel_i(cancel),
    .busy_o(busy), .done_o(done)
  );

  assign rd_addr = (mode == S_ERS_VFY || mode == S_PRG_VFY) ? tgt_addr : addr_i;

  flash_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni, .prog_i(prog), .erase_i(erase), .wr_addr_i(tgt_addr),
    .wr_data_i(prog_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  assign data_o    = (mode == S_SIG) ? (addr_i[0] ? SIG_DEV : SIG_MFG) : rd_data;
  assign data_oe_o = !ce_n_i && !oe_n_i && we_n_i;
  assign busy_o    = busy;

  a_r10_no_drive_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_i || oe_n_i || !we_n_i |-> !data_oe_o);
  a_r1_idle_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !busy_o);
endmodule

// File: tb/tb_flash_cmd_if.sv
`timescale 1ns/1ps
module tb_flash_cmd_if;
  localparam int AW = 4, PC = 12, EC = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic doe, busy;
  int checks = 0, errors = 0;
  logic [7:0] ref_mem [16];
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_if #(.ADDR_W(AW), .PROG_CYC(PC), .ERASE_CYC(EC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .vpp_hi_i(vpp), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .busy_o(busy)
  );

  function automatic logic [7:0] exp_prog(input logic [7:0] old, input logic [7:0] d);
    return old & d;
  endfunction

  function automatic logic [7:0] exp_sig(input logic [AW-1:0] a);
    return a[0] ? 8'hBD : 8'h31;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 1; addr = a; din = d; we_n = 0;
    @(negedge clk); @(negedge clk); we_n = 1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] q);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    #1 q = dout;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic [AW-1:0] a, b;
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 0, "R1 busy", {7'd0, busy}, 8'h00);
    rd(4'd3, q); chk(q == 8'hFF, "R1 array", q, 8'hFF);

    // R10 output enable
    @(negedge clk); ce_n = 1; oe_n = 0; we_n = 1; #1;
    chk(doe == 0, "R10 ce high", {7'd0, doe}, 8'h00);
    @(negedge clk); ce_n = 0; oe_n = 0; #1;
    chk(doe == 1, "R10 enabled", {7'd0, doe}, 8'h01);
    @(negedge clk); oe_n = 1; #1;
    chk(doe == 0, "R10 oe high", {7'd0, doe}, 8'h00);
    @(negedge clk); oe_n = 0; we_n = 0; #1;
    chk(doe == 0, "R10 we low", {7'd0, doe}, 8'h00);
    @(negedge clk); we_n = 1;

    // R2 commands ignored while supply low
    wr(4'd2, 8'h40); wr(4'd2, 8'h00);
    chk(busy == 0, "R2 no pulse", {7'd0, busy}, 8'h00);
    repeat (PC + 4) @(negedge clk);
    rd(4'd2, q); chk(q == 8'hFF, "R2 array kept", q, 8'hFF);
    wr(4'd0, 8'h90); rd(4'd0, q); chk(q == 8'hFF, "R2 sig ignored", q, 8'hFF);

    vpp = 1;
    // R4/R6 random program + program check
    for (int n = 0; n < 10; n++) begin
      a = 4'($urandom % 16);
      b = a + 4'd5;
      d = 8'($urandom);
      wr(a, 8'h40); wr(a, d);
      chk(busy == 1, "R4 busy during pulse", {7'd0, busy}, 8'h01);
      wait_idle();
      ref_mem[a] = exp_prog(ref_mem[a], d);
      wr(4'd0, 8'hC0);
      rd(b, q); chk(q == ref_mem[a], "R6 program check addr", q, ref_mem[a]);
      wr(4'd0, 8'h00);
      rd(a, q); chk(q == ref_mem[a], "R4 programmed byte", q, ref_mem[a]);
      rd(b, q); chk(q == ref_mem[b], "R4 neighbour byte", q, ref_mem[b]);
    end

    // R3 identification
    wr(4'd0, 8'h90);
    rd(4'd0, q); chk(q == exp_sig(4'd0), "R3 mfg", q, exp_sig(4'd0));
    rd(4'd1, q); chk(q == exp_sig(4'd1), "R3 dev", q, exp_sig(4'd1));
    rd(4'd2, q); chk(q == exp_sig(4'd2), "R3 bit0 decode", q, exp_sig(4'd2));

    // R5 erase
    wr(4'd0, 8'h20); wr(4'd0, 8'h20);
    chk(busy == 1, "R5 erase busy", {7'd0, busy}, 8'h01);
    repeat (EC - 6) @(negedge clk);
    chk(busy == 1, "R5 erase length", {7'd0, busy}, 8'h01);
    wait_idle();
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'hFF;
    wr(4'd0, 8'h00);
    rd(4'd9, q); chk(q == 8'hFF, "R5 erased", q, 8'hFF);

    // R6 erase check latches its own address
    wr(4'd7, 8'h40); wr(4'd7, 8'h5A); wait_idle(); ref_mem[7] = 8'h5A;
    wr(4'd7, 8'hA0);
    rd(4'd3, q); chk(q == 8'h5A, "R6 erase check addr", q, 8'h5A);

    // R5 mismatched second erase byte
    wr(4'd0, 8'h20); wr(4'd0, 8'h40);
    chk(busy == 0, "R5 mismatch no pulse", {7'd0, busy}, 8'h00);
    wr(4'd9, 8'h33);
    repeat (PC + 4) @(negedge clk);
    rd(4'd7, q); chk(q == 8'h5A, "R5 mismatch no erase", q, 8'h5A);
    rd(4'd9, q); chk(q == 8'hFF, "R9 unknown byte not data", q, 8'hFF);

    // R7/R8 abort by reset pair
    wr(4'd4, 8'h40); wr(4'd4, 8'h00);
    chk(busy == 1, "R7 pulse running", {7'd0, busy}, 8'h01);
    wr(4'd0, 8'hFF);
    chk(busy == 0, "R7 abort drops busy", {7'd0, busy}, 8'h00);
    wr(4'd0, 8'hFF);
    repeat (PC + 4) @(negedge clk);
    rd(4'd4, q); chk(q == 8'hFF, "R7 aborted byte kept", q, 8'hFF);

    // R7 check command cuts pulse short
    wr(4'd6, 8'h40); wr(4'd6, 8'h00); wr(4'd0, 8'hC0);
    chk(busy == 0, "R7 check ends pulse", {7'd0, busy}, 8'h00);
    rd(4'd1, q); chk(q == 8'hFF, "R7 early end no write", q, 8'hFF);

    // R8 reset pair leaves identification mode
    wr(4'd0, 8'h90); wr(4'd0, 8'hFF); wr(4'd0, 8'hFF);
    rd(4'd0, q); chk(q == 8'hFF, "R8 back to read", q, 8'hFF);

    // R9 unknown command
    wr(4'd0, 8'h90); wr(4'd0, 8'h5C);
    rd(4'd1, q); chk(q == 8'hFF, "R9 unknown to read", q, 8'hFF);

    // R2 supply drop stops pulse
    wr(4'd8, 8'h40); wr(4'd8, 8'h00);
    @(negedge clk); vpp = 0;
    @(negedge clk); @(negedge clk);
    chk(busy == 0, "R2 supply drop", {7'd0, busy}, 8'h00);
    repeat (PC + 4) @(negedge clk);
    rd(4'd8, q); chk(q == 8'hFF, "R2 drop no write", q, 8'hFF);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule